// File: doc/BRIEF.md
# Programmable Trigger Delay Generator

This block places a single output pulse at a programmable time after a trigger edge. It works entirely in the clock domain: the asynchronous trigger is brought in through a synchronizer, and its rising edge is detected. If the active-low enable is low at that edge, the block latches an 8-bit delay code and starts counting. The count advances by one code step every `step_div` clock cycles. When the count reaches the latched code, the block drives a registered pulse of fixed width. The end of that pulse returns the block to idle, ready for the next trigger.

The prescaler input sets the delay span. One code step is `max(step_div,1)` clock cycles, so the full span of 255 steps grows in proportion to the prescaler value. Trigger edges that arrive while a delay or a pulse is in progress are dropped, and a busy output shows when this is the case.

The controller is a three-state machine. IDLE waits for a trigger. DELAY counts code steps. PULSE holds the output high. The named transitions are ACCEPT (IDLE to DELAY: a trigger edge with enable low), MATCH (DELAY to PULSE: the elapsed count equals the latched code) and REARM (PULSE to IDLE: the pulse width has elapsed).

Top module: `trig_delay_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no trigger applied, `pulse_out` and `busy` are 0.
- R2: `trig_in` passes through a two-flop synchronizer. `busy` first reads 1 after the third rising clock edge that follows `trig_in` going high. A trigger held high starts only one cycle.
- R3: A trigger edge is accepted only when `en_n` is 0 at the clock edge that accepts it. With `en_n` at 1, `busy` and `pulse_out` stay 0.
- R4: `delay_code` (bit 0 is the LSB) is latched on acceptance. Changing it later has no effect on the cycle in progress.
- R5: `pulse_out` first goes high 1 + code×D clock cycles after `busy` rises, where D is the step size in cycles.
- R6: The step size D equals `step_div`, and a `step_div` of 0 is treated as 1.
- R7: `pulse_out` is a registered output that stays high for exactly PULSE_W consecutive cycles (default 2).
- R8: `busy` falls on the same edge as `pulse_out`, and a new trigger is accepted from then on.
- R9: A trigger edge that arrives while `busy` is 1 is ignored and produces no further pulse.
- R10: A code of 0 gives a pulse on the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger; the rising edge starts a cycle |
| en_n | input | 1 | Active-low enable, sampled when a trigger edge is detected |
| delay_code | input | CODE_W | Delay in code steps, latched on acceptance |
| step_div | input | PRE_W | Clock cycles per code step (0 counts as 1) |
| pulse_out | output | 1 | Delayed output pulse, PULSE_W cycles wide |
| busy | output | 1 | High while a delay or pulse is in progress |

## Verification
A wrong state value or a wrong step counter shows up first as a shift in the position of the rising edge of `pulse_out`. The bench measures that position to the exact cycle, both relative to the trigger and relative to the rise of `busy`. A code register that is not held stable moves the pulse as soon as `delay_code` changes after acceptance. A lost re-arm shows up as `busy` stuck high past the end of the pulse. A falsely accepted trigger shows up as `busy` rising within three cycles.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } tdg_state_e;
endpackage

// File: rtl/tdg_sync_edge.sv
module tdg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tdg_prescaler.sv
module tdg_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        if (div == '0) last = '0;
        else           last = div - PRE_W'(1);
    end

    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + PRE_W'(1);
    end
endmodule

// File: rtl/tdg_ctrl.sv
module tdg_ctrl
    import tdg_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int PULSE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_rise,
    input  logic              en_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              step_tick,
    output logic              step_run,
    output logic [CODE_W-1:0] code_q,
    output logic              pulse_out,
    output logic              busy
);
    localparam int PW_W = (PULSE_W < 2) ? 1 : $clog2(PULSE_W);
    localparam logic [PW_W-1:0] PW_LAST = PW_W'(PULSE_W - 1);

    tdg_state_e        state_q, state_d;
    logic [CODE_W-1:0] elapsed_q;
    logic [PW_W-1:0]   pw_cnt_q;
    logic              accept;
    logic              match;
    logic              width_done;

    assign accept     = trig_rise && !en_n;
    assign match      = (elapsed_q == code_q);
    assign width_done = (pw_cnt_q == PW_LAST);
    assign step_run   = (state_q == ST_DELAY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)     state_d = ST_DELAY;
            ST_DELAY: if (match)      state_d = ST_PULSE;
            ST_PULSE: if (width_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            elapsed_q <= '0;
            pw_cnt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && accept) code_q <= code_in;
            if (state_q != ST_DELAY)          elapsed_q <= '0;
            else if (step_tick && !match)     elapsed_q <= elapsed_q + CODE_W'(1);
            if (state_q == ST_PULSE)          pw_cnt_q <= pw_cnt_q + PW_W'(1);
            else                              pw_cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            busy      <= 1'b0;
        end else begin
            pulse_out <= (state_d == ST_PULSE);
            busy      <= (state_d != ST_IDLE);
        end
    end
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
    parameter int CODE_W      = 8,
    parameter int PRE_W       = 8,
    parameter int PULSE_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              en_n,
    input  logic [CODE_W-1:0] delay_code,
    input  logic [PRE_W-1:0]  step_div,
    output logic              pulse_out,
    output logic              busy
);
    logic              trig_rise;
    logic              step_tick;
    logic              step_run;
    logic [CODE_W-1:0] cap_code;

    tdg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    tdg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (step_run),
        .div   (step_div),
        .tick  (step_tick)
    );

    tdg_ctrl #(.CODE_W(CODE_W), .PULSE_W(PULSE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_rise (trig_rise),
        .en_n      (en_n),
        .code_in   (delay_code),
        .step_tick (step_tick),
        .step_run  (step_run),
        .code_q    (cap_code),
        .pulse_out (pulse_out),
        .busy      (busy)
    );
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
    parameter int CODE_W  = 8,
    parameter int PULSE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic              trig_rise,
    input logic              pulse_out,
    input logic              busy,
    input logic [CODE_W-1:0] cap_code
);
    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_run <= 0;
        else if (pulse_out) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    AST_PULSE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> busy); // R7

    AST_ACCEPT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(en_n) && $past(trig_rise))); // R3

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cap_code)); // R4

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (hi_run < PULSE_W)); // R7

    AST_PULSE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> ($past(hi_run) == PULSE_W - 1)); // R7

    AST_REARM_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> !busy); // R8

    AST_BUSY_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(pulse_out)); // R8

    AST_PULSE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(busy)); // R5
endmodule

bind trig_delay_gen tdg_checker #(.CODE_W(CODE_W), .PULSE_W(PULSE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_n      (en_n),
    .trig_rise (trig_rise),
    .pulse_out (pulse_out),
    .busy      (busy),
    .cap_code  (cap_code)
);

// File: tb/tb_trig_delay_gen.sv
module tb_trig_delay_gen;
    localparam int PW = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic       en_n = 1'b0;
    logic [7:0] delay_code = 8'd0;
    logic [7:0] step_div = 8'd1;
    logic       pulse_out;
    logic       busy;

    int checks = 0;
    int errors = 0;

    trig_delay_gen #(.PULSE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .en_n(en_n),
        .delay_code(delay_code), .step_div(step_div),
        .pulse_out(pulse_out), .busy(busy)
    );

    always #5 clk = ~clk;

    // {code, div, en_n}
    localparam int NV = 9;
    localparam logic [16:0] VTAB [NV] = '{
        {8'd0,   8'd1, 1'b0},
        {8'd5,   8'd1, 1'b0},
        {8'd3,   8'd4, 1'b0},
        {8'd7,   8'd0, 1'b0},
        {8'd9,   8'd1, 1'b1},
        {8'd1,   8'd3, 1'b0},
        {8'd255, 8'd1, 1'b0},
        {8'd12,  8'd2, 1'b0},
        {8'd0,   8'd5, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raise trigger after a falling edge; count rising edges until idle again.
    task automatic run_cycle(input logic [7:0] code, input logic [7:0] div,
                             input logic en, input int limit, input bit retrig,
                             output int busy_at, output int lat,
                             output int width, output int pulses, output int idle_at);
        logic prev_p;
        @(negedge clk);
        delay_code = code; step_div = div; en_n = en; trig_in = 1'b1;
        busy_at = 0; lat = 0; width = 0; pulses = 0; idle_at = 0; prev_p = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (i == 3) delay_code = ~code;
            if (retrig && i == 6) trig_in = 1'b0;
            if (retrig && i == 9) trig_in = 1'b1;
            if (busy && busy_at == 0) busy_at = i;
            if (pulse_out) begin
                if (lat == 0) lat = i;
                width++;
                if (!prev_p) pulses++;
            end
            if (busy_at != 0 && !busy && idle_at == 0) idle_at = i;
            prev_p = pulse_out;
        end
        trig_in = 1'b0; en_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int busy_at, lat, width, pulses, idle_at, d, exp_lat;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pulse_out in reset", int'(pulse_out), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pulse_out after reset", int'(pulse_out), 0);
        chk("R1 busy after reset", int'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            d = (VTAB[v][8:1] == 0) ? 1 : int'(VTAB[v][8:1]);
            exp_lat = 4 + int'(VTAB[v][16:9]) * d;
            run_cycle(VTAB[v][16:9], VTAB[v][8:1], VTAB[v][0],
                      exp_lat + PW + 4, 1'b0, busy_at, lat, width, pulses, idle_at);
            if (VTAB[v][0]) begin
                chk("R3 no busy when disabled", busy_at, 0);
                chk("R3 no pulse when disabled", lat, 0);
            end else begin
                chk("R2 busy three edges after trigger", busy_at, 3);
                chk("R4 R5 R6 R10 pulse latency", lat, exp_lat);
                chk("R5 pulse after busy rise", lat - busy_at, 1 + int'(VTAB[v][16:9]) * d);
                chk("R7 pulse width", width, PW);
                chk("R8 busy falls with pulse", idle_at, exp_lat + PW);
            end
        end

        // R2: a held trigger starts only one cycle
        @(negedge clk);
        delay_code = 8'd2; step_div = 8'd1; trig_in = 1'b1;
        pulses = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (pulse_out && i == 6) pulses++;
            if (i > 12 && busy) pulses += 10;
        end
        chk("R2 held trigger gives one cycle", pulses, 1);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);

        // R9: a trigger edge during busy is ignored
        run_cycle(8'd20, 8'd2, 1'b0, 60, 1'b1, busy_at, lat, width, pulses, idle_at);
        chk("R9 single pulse despite retrigger", pulses, 1);
        chk("R9 latency unchanged", lat, 44);
        chk("R9 idle after pulse", idle_at, 44 + PW);

        // R8: re-arm, next trigger accepted right after
        run_cycle(8'd1, 8'd1, 1'b0, 12, 1'b0, busy_at, lat, width, pulses, idle_at);
        chk("R8 rearmed trigger accepted", busy_at, 3);
        chk("R8 rearmed latency", lat, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule